// File: doc/BRIEF.md
# Operand-Handshake Computation Unit Controller

This controller sits between an out-of-order issue stage and a small combinational ALU. A one-cycle issue pulse hands it an operation record: an add/pass selector, an invert-A flag, a zero-A flag, and an immediate with its valid bit. It also takes an active-low read mask. The controller then asks for each source operand it still needs, using a separate release line for each read port. It stores each operand when the matching go pulse arrives.

Once every requested operand is held, the unit evaluates the ALU and registers the result. It raises write-release and keeps the result steady until a one-cycle write-go pulse retires the operation and frees the unit. The number of source ports (two or three) and the data width are parameters. A port that needs no read never raises its release line. Such a port counts as already satisfied.

Top module: `opcu_ctrl`

## Requirements
- R1: A synchronous active-high reset clears busy, every read-release bit, write-release and the result register.
- R2: An issue pulse while idle latches the operation record and mask, and busy is high from the next cycle. An issue pulse while busy is ignored.
- R3: Each required read-release bit rises on the cycle after issue. It stays high until its own go bit is seen, whatever the other ports do.
- R4: A go bit seen with its release high captures that port's slice of `src` (port i at bits i*DW upward), and that release falls on the next cycle. A go bit with its release low is ignored.
- R5: With zero-A set, operand A is zero and port 0 requests no read.
- R6: With the immediate-valid bit set, operand B takes the immediate and port 1 requests no read.
- R7: With invert-A set, A is bitwise inverted after any zero forcing. With 16-bit data, adding inverted 5 and 2 gives 65532.
- R8: `op_add`=1 gives the sum of A and all other operands modulo 2^DW. `op_add`=0 (NOP) gives A after zero forcing and inversion.
- R9: A read-mask bit of 0 suppresses that port's read. That operand then counts as zero.
- R10: Write-release rises on the cycle after the last operand is captured, or two cycles after issue when no read is needed. The result stays valid and stable while write-release is high.
- R11: A write-go pulse with write-release high clears busy, write-release and all read-release bits on the next cycle.
- R12: With three ports, port 2 has its own release and go bit (bit 2), handled independently of ports 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | One-cycle operation issue pulse |
| op_add | input | 1 | 1 = add, 0 = pass A (NOP) |
| inv_a | input | 1 | Invert operand A |
| zero_a | input | 1 | Force operand A to zero, skip its read |
| imm | input | DW | Immediate value |
| imm_vld | input | 1 | Immediate replaces operand B, skip its read |
| rd_mask_n | input | NSRC | Active-low per-port read mask |
| rd_go | input | NSRC | Per-port read go pulses |
| src | input | NSRC*DW | Operand data, port i at bits [i*DW +: DW] |
| wr_go | input | 1 | Write go pulse |
| busy | output | 1 | Operation in flight |
| rd_rel | output | NSRC | Per-port read release |
| wr_rel | output | 1 | Result valid, write requested |
| result | output | DW | ALU result |

## Verification
Read-release is due one cycle after the issue edge. A release falls one cycle after its go edge. Write-release follows one cycle after the last capture, or one cycle after release would have appeared when nothing is read. Busy drops one cycle after write-go. The bench drives every input on the falling edge and samples on the following falling edge, so each check falls in the exact cycle its result becomes due. Before that cycle it confirms that the output has not yet changed, for example write-release low while a capture is still registering. A staggered scenario holds releases for several cycles and fires go bits one port at a time. In the same scenario it injects a stray go and an issue while busy, and checks through the release lines and the final sum that neither took effect.

// File: rtl/opcu_ctrl.sv
module opcu_ctrl #(
  parameter int DW   = 16,
  parameter int NSRC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic             op_add,
  input  logic             inv_a,
  input  logic             zero_a,
  input  logic [DW-1:0]    imm,
  input  logic             imm_vld,
  input  logic [NSRC-1:0]  rd_mask_n,
  input  logic [NSRC-1:0]  rd_go,
  input  logic [NSRC*DW-1:0] src,
  input  logic             wr_go,
  output logic             busy,
  output logic [NSRC-1:0]  rd_rel,
  output logic             wr_rel,
  output logic [DW-1:0]    result
);

  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] need;
  logic [DW-1:0]   opnd [NSRC];
  logic            add_q, inv_q, done;
  logic            accept;
  logic [DW-1:0]   a_eff, sum, alu_out;

  assign accept = issue & ~busy;

  always_comb begin
    need    = rd_mask_n;
    need[0] = rd_mask_n[0] & ~zero_a;
    need[1] = rd_mask_n[1] & ~imm_vld;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      for (int i = 0; i < NSRC; i++) opnd[i] <= '0;
    end else if (accept) begin
      pend <= need;
      for (int i = 0; i < NSRC; i++)
        opnd[i] <= (i == 1 && imm_vld) ? imm : '0;
    end else begin
      for (int i = 0; i < NSRC; i++)
        if (rd_go[i] && pend[i]) begin
          opnd[i] <= src[i*DW +: DW];
          pend[i] <= 1'b0;
        end
    end
  end

  assign a_eff = inv_q ? ~opnd[0] : opnd[0];

  always_comb begin
    sum = a_eff;
    for (int i = 1; i < NSRC; i++) sum = sum + opnd[i];
  end

  assign alu_out = add_q ? sum : a_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      add_q  <= 1'b0;
      inv_q  <= 1'b0;
      result <= '0;
    end else begin
      if (accept) begin
        busy  <= 1'b1;
        add_q <= op_add;
        inv_q <= inv_a;
      end
      if (busy && !done && pend == '0) begin
        result <= alu_out;
        done   <= 1'b1;
      end
      if (done && wr_go) begin
        busy <= 1'b0;
        done <= 1'b0;
      end
    end
  end

  assign rd_rel = pend;
  assign wr_rel = done;

endmodule

module opcu_ctrl_chk #(
  parameter int DW   = 16,
  parameter int NSRC = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            issue,
  input logic            busy,
  input logic [NSRC-1:0] rd_rel,
  input logic [NSRC-1:0] rd_go,
  input logic            wr_rel,
  input logic            wr_go,
  input logic [DW-1:0]   result
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (rd_rel == '0 && !wr_rel));

  assert_issue_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (issue && !busy) |=> busy);

  assert_rel_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_rel & ~rd_go) != '0 |=>
      ((rd_rel & $past(rd_rel & ~rd_go)) == $past(rd_rel & ~rd_go)));

  assert_rel_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_rel & rd_go) != '0 |=> ((rd_rel & $past(rd_rel & rd_go)) == '0));

  assert_wr_after_reads_R10: assert property (@(posedge clk) disable iff (rst)
    wr_rel |-> (rd_rel == '0 && busy));

  assert_result_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_rel && !wr_go) |=> (wr_rel && $stable(result)));

  assert_retire_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_rel && wr_go) |=> (!busy && !wr_rel && rd_rel == '0));

endmodule

bind opcu_ctrl opcu_ctrl_chk #(.DW(DW), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst(rst), .issue(issue), .busy(busy), .rd_rel(rd_rel),
  .rd_go(rd_go), .wr_rel(wr_rel), .wr_go(wr_go), .result(result)
);

// File: tb/opcu_ctrl_tb.sv
module opcu_ctrl_tb;
  localparam int DW = 16;
  localparam int NS = 3;

  logic clk = 1'b0;
  logic rst, issue, op_add, inv_a, zero_a, imm_vld, wr_go;
  logic [DW-1:0] imm;
  logic [NS-1:0] rd_mask_n, rd_go;
  logic [NS*DW-1:0] src;
  logic busy, wr_rel;
  logic [NS-1:0] rd_rel;
  logic [DW-1:0] result;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  opcu_ctrl #(.DW(DW), .NSRC(NS)) u_dut (
    .clk(clk), .rst(rst), .issue(issue), .op_add(op_add), .inv_a(inv_a),
    .zero_a(zero_a), .imm(imm), .imm_vld(imm_vld), .rd_mask_n(rd_mask_n),
    .rd_go(rd_go), .src(src), .wr_go(wr_go), .busy(busy), .rd_rel(rd_rel),
    .wr_rel(wr_rel), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic run_op(input string tag, input logic add, input logic inv,
                        input logic zro, input logic iv, input logic [DW-1:0] im,
                        input logic [NS-1:0] mk, input logic [DW-1:0] a,
                        input logic [DW-1:0] b, input logic [DW-1:0] c,
                        input logic [DW-1:0] exp, input logic [NS-1:0] reads);
    logic [DW-1:0] held;
    @(negedge clk);
    issue = 1; op_add = add; inv_a = inv; zero_a = zro; imm_vld = iv; imm = im;
    rd_mask_n = mk;
    @(negedge clk);
    issue = 0; op_add = 0; inv_a = 0; zero_a = 0; imm_vld = 0; imm = '0;
    chk(busy == 1'b1, {tag, " R2 busy"}, int'(busy), 1);
    chk(rd_rel == reads, {tag, " R3 rd_rel"}, int'(rd_rel), int'(reads));
    rd_go = rd_rel; src = {c, b, a};
    @(negedge clk);
    rd_go = '0; src = '0;
    if (reads != '0) begin
      chk(rd_rel == '0, {tag, " R4 rel falls"}, int'(rd_rel), 0);
      chk(wr_rel == 1'b0, {tag, " R10 not yet"}, int'(wr_rel), 0);
      @(negedge clk);
    end
    chk(wr_rel == 1'b1, {tag, " R10 wr_rel"}, int'(wr_rel), 1);
    chk(result == exp, {tag, " result"}, int'(result), int'(exp));
    held = result;
    @(negedge clk);
    chk(wr_rel && result == held, {tag, " R10 hold"}, int'(result), int'(held));
    wr_go = 1;
    @(negedge clk);
    wr_go = 0;
    chk(!busy && !wr_rel && rd_rel == '0, {tag, " R11 retire"},
        int'({busy, wr_rel, rd_rel}), 0);
  endtask

  task automatic staggered();
    @(negedge clk);
    issue = 1; op_add = 1; rd_mask_n = 3'b111;
    @(negedge clk);
    issue = 0; op_add = 0;
    repeat (2) @(negedge clk);
    chk(rd_rel == 3'b111, "R3 held without go", int'(rd_rel), 7);
    rd_go = 3'b010; src = {16'd0, 16'd23, 16'd0};
    @(negedge clk);
    rd_go = 3'b010; src = {16'd0, 16'd999, 16'd0};
    issue = 1; op_add = 0;
    chk(rd_rel == 3'b101, "R4 only port1 dropped", int'(rd_rel), 5);
    @(negedge clk);
    rd_go = '0; issue = 0;
    chk(rd_rel == 3'b101, "R12 port2 independent", int'(rd_rel), 5);
    rd_go = 3'b100; src = {16'd7, 16'd0, 16'd0};
    @(negedge clk);
    chk(rd_rel == 3'b001, "R12 port2 drops", int'(rd_rel), 1);
    rd_go = 3'b001; src = {16'd0, 16'd0, 16'd100};
    @(negedge clk);
    rd_go = '0; src = '0;
    chk(wr_rel == 1'b0, "R10 one cycle after capture", int'(wr_rel), 0);
    @(negedge clk);
    chk(wr_rel == 1'b1, "R10 wr_rel", int'(wr_rel), 1);
    chk(result == 16'd130, "R4 R2 stray go and busy issue ignored",
        int'(result), 130);
    wr_go = 1;
    @(negedge clk);
    wr_go = 0;
    chk(!busy, "R11 idle", int'(busy), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1; issue = 0; op_add = 0; inv_a = 0; zero_a = 0; imm_vld = 0;
    imm = '0; rd_mask_n = '1; rd_go = '0; src = '0; wr_go = 0;
    repeat (3) @(negedge clk);
    chk(!busy && rd_rel == '0 && !wr_rel && result == '0, "R1 reset",
        int'({busy, rd_rel, wr_rel}), 0);
    rst = 0;
    run_op("R6 imm",        1, 0, 0, 1, 16'd8, 3'b011, 16'd5, 16'd2, 16'd0, 16'd13,    3'b001);
    run_op("R5 zero imm",   1, 0, 1, 1, 16'd8, 3'b011, 16'd5, 16'd2, 16'd0, 16'd8,     3'b000);
    run_op("R8 add",        1, 0, 0, 0, 16'd0, 3'b011, 16'd5, 16'd2, 16'd0, 16'd7,     3'b011);
    run_op("R7 invert",     1, 1, 0, 0, 16'd0, 3'b011, 16'd5, 16'd2, 16'd0, 16'd65532, 3'b011);
    run_op("R5 zero",       1, 0, 1, 0, 16'd0, 3'b011, 16'd5, 16'd2, 16'd0, 16'd2,     3'b010);
    run_op("R8 nop",        0, 0, 0, 0, 16'd0, 3'b011, 16'd9, 16'd2, 16'd0, 16'd9,     3'b011);
    run_op("R8 wrap",       1, 0, 0, 0, 16'd0, 3'b011, 16'hFFFF, 16'd2, 16'd0, 16'd1,  3'b011);
    run_op("R9 mask",       1, 0, 0, 0, 16'd0, 3'b110, 16'd5, 16'd2, 16'd4, 16'd6,     3'b110);
    run_op("R12 three",     1, 0, 0, 0, 16'd0, 3'b111, 16'd1, 16'd2, 16'd3, 16'd6,     3'b111);
    run_op("R7 zero inv",   0, 1, 1, 0, 16'd0, 3'b011, 16'd5, 16'd2, 16'd0, 16'hFFFF,  3'b010);
    staggered();
    finish_run();
  end
endmodule